// File: doc/BRIEF.md
# Serial Line Arbiter and Bit-Timer

This block sits next to a UART-style transmitter and receiver and shares one 9-bit counter between two jobs. In arbitration mode it watches the line on a shared bus. The counter restarts on each rising edge of the transmitter's internal data signal. At a fixed count it takes one sample of the synchronized receive line. If another node is holding the line low at that point, the node has lost the bus, and from then on the block forces its own transmit pin to the recessive level of 1.

In bit-time mode the same counter measures received pulses, so that software can recover the baud rate or time a break. The clock-select bit picks one of two count strobes supplied from outside and also picks the rule that starts and stops the count. With select 0, the count runs from one falling edge of the receive line to the next falling edge. With select 1, it runs while the line is low and stops on the following rising edge.

A single write port loads the mode and clock-select bits. Every write also clears the counter, the overflow flag and all status flags. The count, the overflow flag, the lost flag and the running and finished flags are read-only outputs.

Top module: `serial_arb_timer`

## Requirements
- R1: After reset the count, the overflow flag, the lost flag, the running flag and the finished flag are all 0, and `txd_o` follows `tx_data_i`.
- R2: A write (`cfg_we`=1) loads `cfg_wdata[1:0]` as the mode and `cfg_wdata[2]` as the clock select, which `cfg_q` shows at the next edge. The same write clears the count, the overflow flag, the lost flag, the running flag and the finished flag at that edge.
- R3: In mode 00 or mode 11 the count stays 0 and the running flag stays 0, whatever the strobes, `rxd_i` and `tx_data_i` do.
- R4: In mode 10 (arbitration), a rising edge of `tx_data_i` clears the count and starts it at the next edge. After that, the count rises by one at each edge where the selected strobe is high.
- R5: In mode 10, the synchronized receive level is sampled once per transmit rising edge, on the cycle the count equals 0x38 (select 0) or 0x08 (select 1). If that sample is 0, the lost flag sets.
- R6: While the lost flag is 1, `txd_o` is 1. The lost flag stays set until a write or a reset.
- R7: In mode 01 with select 0, the count starts from 0 on a falling edge of the synchronized `rxd_i` and stops on the next falling edge.
- R8: In mode 01 with select 1, the count starts from 0 whenever the synchronized `rxd_i` is 0, including when it is already 0 at the time of the write. It stops on the next rising edge.
- R9: In mode 01 the running flag is 1 while counting. At the stop event the running flag clears and the finished flag sets. No new measurement starts until the next write.
- R10: A count step from 511 wraps the count to 0 and sets the overflow flag. The overflow flag then stays set until a write or a reset.
- R11: With select 0 only `tick_bus_i` advances the count, and with select 1 only `tick_pre_i` does. The unselected strobe has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_wdata | input | 3 | Write data: [2] clock select, [1:0] mode |
| cfg_q | output | 3 | Current control register |
| tx_data_i | input | 1 | Internal transmit data from the transmitter |
| rxd_i | input | 1 | Receive pin (asynchronous) |
| txd_o | output | 1 | Transmit pin, forced to 1 after arbitration loss |
| tick_bus_i | input | 1 | Count strobe for select 0 (bus clock divided by 4) |
| tick_pre_i | input | 1 | Count strobe for select 1 (half the prescaler clock) |
| cnt_hi_o | output | 1 | Count bit 8 |
| cnt_lo_o | output | 8 | Count bits 7..0 |
| ovf_o | output | 1 | Counter overflow flag |
| lost_o | output | 1 | Arbitration lost flag |
| run_o | output | 1 | Measurement or arbitration count running |
| fin_o | output | 1 | Measurement finished |

## Verification
A write, a transmit rising edge or a strobe shows in the count and flags one edge later. A change on `rxd_i` passes two synchronizer flops and an edge register, so its start, stop or sample effect appears at the third edge after it is driven, while `txd_o` reacts combinationally to the lost flag. The bench drives inputs just after the falling edge. A behavioural model steps on every rising edge with those same latencies built in as a sample history, and the outputs are compared with the model at each falling edge. Directed checks at the end of each scenario confirm the flag outcomes that the requirements call for.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_BIT  = 2'b01,
    MODE_ARB  = 2'b10,
    MODE_OFF2 = 2'b11
  } sat_mode_e;
endpackage

// File: rtl/sat_rx_sync.sv
module sat_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_clr_i,
  input  logic             ovf_clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (ovf_clr_i) ovf_d = 1'b0;
    if (cnt_clr_i) begin
      cnt_d = '0;
    end else if (inc_i) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_MAX) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  // R2
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_i |=> (cnt_q == '0));
  // R10
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && inc_i && !cnt_clr_i) |=> (cnt_q == '0 && ovf_q));
  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr_i) |=> ovf_q);
endmodule

// File: rtl/sat_ctrl.sv
module sat_ctrl
  import sat_pkg::*;
#(
  parameter int               CNT_W   = 9,
  parameter logic [CNT_W-1:0] ARB_AT0 = 9'h038,
  parameter logic [CNT_W-1:0] ARB_AT1 = 9'h008
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [2:0]       wdata_i,
  input  logic             tx_data_i,
  input  logic             rx_lvl_i,
  input  logic             rx_rise_i,
  input  logic             rx_fall_i,
  input  logic             tick_bus_i,
  input  logic             tick_pre_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [2:0]       cfg_o,
  output logic             cnt_clr_o,
  output logic             ovf_clr_o,
  output logic             inc_o,
  output logic             lost_o,
  output logic             run_o,
  output logic             fin_o
);
  sat_mode_e mode_q, mode_d;
  logic      csel_q, csel_d;
  logic      run_q, run_d;
  logic      fin_q, fin_d;
  logic      lost_q, lost_d;
  logic      armed_q, armed_d;
  logic      txp_q;

  logic             tx_rise;
  logic             tick_sel;
  logic [CNT_W-1:0] arb_at;
  logic             start_ev, stop_ev;

  always_comb begin
    tx_rise  = tx_data_i & ~txp_q;
    tick_sel = csel_q ? tick_pre_i : tick_bus_i;
    arb_at   = csel_q ? ARB_AT1 : ARB_AT0;
    start_ev = csel_q ? ~rx_lvl_i : rx_fall_i;
    stop_ev  = csel_q ? rx_rise_i : rx_fall_i;
  end

  always_comb begin
    mode_d    = mode_q;
    csel_d    = csel_q;
    run_d     = run_q;
    fin_d     = fin_q;
    lost_d    = lost_q;
    armed_d   = armed_q;
    cnt_clr_o = 1'b0;
    ovf_clr_o = 1'b0;
    inc_o     = 1'b0;
    if (we_i) begin
      mode_d    = sat_mode_e'(wdata_i[1:0]);
      csel_d    = wdata_i[2];
      run_d     = 1'b0;
      fin_d     = 1'b0;
      lost_d    = 1'b0;
      armed_d   = 1'b0;
      cnt_clr_o = 1'b1;
      ovf_clr_o = 1'b1;
    end else begin
      unique case (mode_q)
        MODE_ARB: begin
          if (tx_rise) begin
            cnt_clr_o = 1'b1;
            run_d     = 1'b1;
            armed_d   = 1'b1;
          end else begin
            if (armed_q && cnt_i == arb_at) begin
              armed_d = 1'b0;
              if (!rx_lvl_i) lost_d = 1'b1;
            end
            inc_o = run_q & tick_sel;
          end
        end
        MODE_BIT: begin
          if (run_q) begin
            if (stop_ev) begin
              run_d = 1'b0;
              fin_d = 1'b1;
            end else begin
              inc_o = tick_sel;
            end
          end else if (!fin_q && start_ev) begin
            run_d     = 1'b1;
            cnt_clr_o = 1'b1;
          end
        end
        default: begin
          run_d     = 1'b0;
          armed_d   = 1'b0;
          cnt_clr_o = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_OFF;
      csel_q  <= 1'b0;
      run_q   <= 1'b0;
      fin_q   <= 1'b0;
      lost_q  <= 1'b0;
      armed_q <= 1'b0;
      txp_q   <= 1'b1;
    end else begin
      mode_q  <= mode_d;
      csel_q  <= csel_d;
      run_q   <= run_d;
      fin_q   <= fin_d;
      lost_q  <= lost_d;
      armed_q <= armed_d;
      txp_q   <= tx_data_i;
    end
  end

  assign cfg_o  = {csel_q, mode_q};
  assign lost_o = lost_q;
  assign run_o  = run_q;
  assign fin_o  = fin_q;

  // R6
  lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_q && !we_i) |=> lost_q);
  // R3
  idle_norun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_OFF || mode_q == MODE_OFF2) && !we_i) |=> !run_q);
  // R9
  runfin_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_q && fin_q));
  // R4
  arb_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ARB && tx_rise && !we_i) |=> (run_q && cnt_i == '0));
endmodule

// File: rtl/serial_arb_timer.sv
module serial_arb_timer #(
  parameter int CNT_W       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [2:0] cfg_wdata,
  output logic [2:0] cfg_q,
  input  logic       tx_data_i,
  input  logic       rxd_i,
  output logic       txd_o,
  input  logic       tick_bus_i,
  input  logic       tick_pre_i,
  output logic       cnt_hi_o,
  output logic [7:0] cnt_lo_o,
  output logic       ovf_o,
  output logic       lost_o,
  output logic       run_o,
  output logic       fin_o
);
  localparam logic [CNT_W-1:0] ARB_AT0 = CNT_W'(56);
  localparam logic [CNT_W-1:0] ARB_AT1 = CNT_W'(8);

  logic             rx_lvl, rx_rise, rx_fall;
  logic             cnt_clr, ovf_clr, inc;
  logic [CNT_W-1:0] cnt;
  logic             lost;

  sat_rx_sync #(.STAGES(SYNC_STAGES)) rx_sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (rxd_i),
    .lvl_o  (rx_lvl),
    .rise_o (rx_rise),
    .fall_o (rx_fall)
  );

  sat_ctrl #(.CNT_W(CNT_W), .ARB_AT0(ARB_AT0), .ARB_AT1(ARB_AT1)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (cfg_we),
    .wdata_i    (cfg_wdata),
    .tx_data_i  (tx_data_i),
    .rx_lvl_i   (rx_lvl),
    .rx_rise_i  (rx_rise),
    .rx_fall_i  (rx_fall),
    .tick_bus_i (tick_bus_i),
    .tick_pre_i (tick_pre_i),
    .cnt_i      (cnt),
    .cfg_o      (cfg_q),
    .cnt_clr_o  (cnt_clr),
    .ovf_clr_o  (ovf_clr),
    .inc_o      (inc),
    .lost_o     (lost),
    .run_o      (run_o),
    .fin_o      (fin_o)
  );

  sat_counter #(.CNT_W(CNT_W)) counter_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_clr_i (cnt_clr),
    .ovf_clr_i (ovf_clr),
    .inc_i     (inc),
    .cnt_o     (cnt),
    .ovf_o     (ovf_o)
  );

  assign txd_o    = lost | tx_data_i;
  assign lost_o   = lost;
  assign cnt_hi_o = cnt[CNT_W-1];
  assign cnt_lo_o = cnt[7:0];

  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_q == $past(cfg_wdata) && !lost && !run_o && !fin_o && !ovf_o));
endmodule

// File: tb/serial_arb_timer_tb_top.sv
module serial_arb_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [2:0] cfg_wdata;
  logic [2:0] cfg_q;
  logic       tx_data_i, rxd_i, txd_o;
  logic       tick_bus_i, tick_pre_i;
  logic       cnt_hi_o;
  logic [7:0] cnt_lo_o;
  logic       ovf_o, lost_o, run_o, fin_o;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string cur_req = "R1";
  int    bus_per = 0;
  int    pre_per = 0;
  int    kcyc = 0;

  // behavioural reference state
  int m_cnt, m_mode, m_csel;
  bit m_ovf, m_lost, m_run, m_fin, m_armed, m_txp;
  bit rxh[$];

  always #2 clk = ~clk;

  serial_arb_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .tx_data_i(tx_data_i), .rxd_i(rxd_i), .txd_o(txd_o),
    .tick_bus_i(tick_bus_i), .tick_pre_i(tick_pre_i),
    .cnt_hi_o(cnt_hi_o), .cnt_lo_o(cnt_lo_o), .ovf_o(ovf_o),
    .lost_o(lost_o), .run_o(run_o), .fin_o(fin_o)
  );

  task automatic model_reset();
    m_cnt = 0; m_mode = 0; m_csel = 0;
    m_ovf = 0; m_lost = 0; m_run = 0; m_fin = 0; m_armed = 0; m_txp = 1;
    rxh = '{1, 1, 1};
  endtask

  task automatic bump();
    if (m_cnt == 511) begin m_cnt = 0; m_ovf = 1; end
    else m_cnt = m_cnt + 1;
  endtask

  // rxh[0]: sampled one edge ago, rxh[1]: two edges ago, rxh[2]: three edges ago
  task automatic model_step();
    bit s_now, s_old, fall, rise, txr, tk, ev;
    s_now = rxh[1];
    s_old = rxh[2];
    fall  = s_old && !s_now;
    rise  = !s_old && s_now;
    txr   = tx_data_i && !m_txp;
    tk    = m_csel ? tick_pre_i : tick_bus_i;
    if (cfg_we) begin
      m_mode = cfg_wdata[1:0]; m_csel = cfg_wdata[2];
      m_cnt = 0; m_ovf = 0; m_lost = 0; m_run = 0; m_fin = 0; m_armed = 0;
    end else if (m_mode == 2) begin
      if (txr) begin m_cnt = 0; m_run = 1; m_armed = 1; end
      else begin
        if (m_armed && m_cnt == (m_csel ? 8 : 56)) begin
          m_armed = 0;
          if (!s_now) m_lost = 1;
        end
        if (m_run && tk) bump();
      end
    end else if (m_mode == 1) begin
      if (m_run) begin
        ev = m_csel ? rise : fall;
        if (ev) begin m_run = 0; m_fin = 1; end
        else if (tk) bump();
      end else if (!m_fin) begin
        ev = m_csel ? !s_now : fall;
        if (ev) begin m_run = 1; m_cnt = 0; end
      end
    end else begin
      m_cnt = 0; m_run = 0; m_armed = 0;
    end
    m_txp = tx_data_i;
    rxh.push_front(rxd_i);
    void'(rxh.pop_back());
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  // cycle compare against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if ({cnt_hi_o, cnt_lo_o} !== 9'(m_cnt) || ovf_o !== m_ovf || lost_o !== m_lost ||
          run_o !== m_run || fin_o !== m_fin || txd_o !== (m_lost | tx_data_i) ||
          cfg_q !== {1'(m_csel), 2'(m_mode)}) begin
        errors++;
        $display("FAIL %s t=%0t act cnt=%0d ovf=%0b lost=%0b run=%0b fin=%0b txd=%0b cfg=%0d exp cnt=%0d ovf=%0b lost=%0b run=%0b fin=%0b txd=%0b cfg=%0d",
                 cur_req, $time, {cnt_hi_o, cnt_lo_o}, ovf_o, lost_o, run_o, fin_o, txd_o, cfg_q,
                 m_cnt, m_ovf, m_lost, m_run, m_fin, m_lost | tx_data_i, m_csel * 4 + m_mode);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      cfg_we     = 1'b0;
      kcyc++;
      tick_bus_i = (bus_per != 0) && (kcyc % bus_per == 0);
      tick_pre_i = (pre_per != 0) && (kcyc % pre_per == 0);
    end
  endtask

  task automatic wr(input logic [2:0] v);
    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); #1;
    cfg_we = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_wdata = 0; tx_data_i = 0; rxd_i = 1;
    tick_bus_i = 0; tick_pre_i = 0;
    #15;
    // R1 reset state
    chk({cnt_hi_o, cnt_lo_o} == 0 && !ovf_o && !lost_o && !run_o && !fin_o, "R1",
        {cnt_hi_o, cnt_lo_o}, 0);
    chk(txd_o == tx_data_i, "R1", txd_o, tx_data_i);
    @(negedge clk); #1; rst_n = 1;
    cycles(4);

    // R3 idle modes ignore strobes and line activity
    cur_req = "R3"; bus_per = 1; pre_per = 1;
    wr(3'b000);
    for (int j = 0; j < 6; j++) begin
      tx_data_i = ~tx_data_i; rxd_i = ~rxd_i; cycles(5);
    end
    wr(3'b111);
    for (int j = 0; j < 6; j++) begin
      tx_data_i = ~tx_data_i; rxd_i = ~rxd_i; cycles(5);
    end
    chk({cnt_hi_o, cnt_lo_o} == 0 && !run_o, "R3", {cnt_hi_o, cnt_lo_o}, 0);
    rxd_i = 1; tx_data_i = 0; cycles(5);

    // R4 R5 arbitration, select 1, line high: no loss
    cur_req = "R4/R5"; bus_per = 0; pre_per = 1;
    wr(3'b110);
    cycles(3); tx_data_i = 1; cycles(20);
    chk(lost_o == 0, "R5", lost_o, 0);
    chk(cfg_q == 3'b110, "R2", cfg_q, 6);
    // line low at the sample point: loss, pin forced high
    cur_req = "R5/R6";
    tx_data_i = 0; rxd_i = 0; cycles(3); tx_data_i = 1; cycles(20);
    chk(lost_o == 1, "R5", lost_o, 1);
    tx_data_i = 0; cycles(2);
    chk(txd_o == 1, "R6", txd_o, 1);
    // lost stays set across new transmit edges with line high
    rxd_i = 1; tx_data_i = 1; cycles(20); tx_data_i = 0; cycles(4);
    chk(lost_o == 1 && txd_o == 1, "R6", lost_o, 1);

    // R2 write clears; R11 arbitration select 0 with the other strobe busy
    cur_req = "R2/R11"; bus_per = 2; pre_per = 1;
    wr(3'b010);
    chk(lost_o == 0 && txd_o == tx_data_i, "R2", lost_o, 0);
    rxd_i = 0; cycles(3); tx_data_i = 1; cycles(90);
    chk(lost_o == 0, "R11", lost_o, 0);
    cycles(40);
    chk(lost_o == 1, "R5", lost_o, 1);
    tx_data_i = 0; rxd_i = 1; cycles(4);

    // R7 R9 bit time, select 0
    cur_req = "R7/R9"; bus_per = 4; pre_per = 1;
    wr(3'b001);
    cycles(5); rxd_i = 0; cycles(6);
    chk(run_o == 1, "R9", run_o, 1);
    cycles(30); rxd_i = 1; cycles(10); rxd_i = 0; cycles(6);
    chk(run_o == 0 && fin_o == 1, "R9", fin_o, 1);
    chk({cnt_hi_o, cnt_lo_o} >= 11 && {cnt_hi_o, cnt_lo_o} <= 13, "R7",
        {cnt_hi_o, cnt_lo_o}, 12);
    rxd_i = 1; cycles(6); rxd_i = 0; cycles(10);
    chk(run_o == 0 && fin_o == 1, "R9", run_o, 0);

    // R8 bit time, select 1, line already low at the write
    cur_req = "R8"; bus_per = 1; pre_per = 1;
    wr(3'b101);
    cycles(20);
    chk(run_o == 1, "R8", run_o, 1);
    rxd_i = 1; cycles(6);
    chk(fin_o == 1 && {cnt_hi_o, cnt_lo_o} > 18, "R8", {cnt_hi_o, cnt_lo_o}, 22);
    // select 1 from a high line, low pulse only on the unselected strobe
    bus_per = 1; pre_per = 0;
    wr(3'b101);
    cycles(4); rxd_i = 0; cycles(15); rxd_i = 1; cycles(6);
    chk(fin_o == 1 && {cnt_hi_o, cnt_lo_o} == 0, "R11", {cnt_hi_o, cnt_lo_o}, 0);

    // R10 overflow in a long low pulse
    cur_req = "R10"; bus_per = 0; pre_per = 1;
    wr(3'b101);
    rxd_i = 0; cycles(530);
    chk(ovf_o == 1 && run_o == 1, "R10", ovf_o, 1);
    chk({cnt_hi_o, cnt_lo_o} < 40, "R10", {cnt_hi_o, cnt_lo_o}, 20);
    cur_req = "R2";
    wr(3'b000);
    chk(ovf_o == 0 && {cnt_hi_o, cnt_lo_o} == 0 && fin_o == 0, "R2", ovf_o, 0);
    rxd_i = 1; cycles(5);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule